// File: doc/BRIEF.md
# UART Receiver with Line Status Word

This block is the receive half of an asynchronous serial port. It watches a serial input with a 16x oversampling tick, finds and validates start bits, and recovers characters of 5 to 8 data bits. Each character has optional even or odd parity and one or two stop bits. Every recovered character is queued in a 16-entry receive FIFO. Each entry carries its own parity, framing and break tags.

Software sees two things: the byte at the FIFO head, and an 8-bit line status word. The status word shows whether data is waiting, overrun, and the error tags of the head byte. It also shows whether any queued byte is erroneous, and the two empty conditions reported by the transmit side. A data-read strobe removes the head byte. A status-read strobe acknowledges the sticky status bits.

A long run of continuous space on the line is reported as a break. A break queues exactly one zero byte. The receiver then waits for the line to return to mark before it looks for a new start bit.

Top module: `uart_rx_lsr`

## Requirements
- R1: While reset is held and after reset, status bits 0 to 4 and 7 are 0 and the FIFO is empty.
- R2: A valid frame is deframed LSB first. After the frame, status bit 0 is 1 and `rd_data` shows the byte. Each `rd_data_strobe` removes the head byte, and bit 0 returns to 0 once the FIFO is read empty.
- R3: `cfg_wlen` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Unused upper bits of `rd_data` read 0.
- R4: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_even`=1 means even parity and 0 means odd parity. On a mismatch the byte is tagged, and status bit 2 is 1 while that byte is at the head.
- R5: A 0 sampled in the first stop position tags the byte with a framing error, shown in status bit 3. The receiver then waits for the line to go high before it searches for a new start bit.
- R6: If the line stays low longer than one full character time (start, data, parity and stop bits), exactly one byte 0x00 tagged as break is queued, and status bit 4 shows the tag. No further byte is queued until the line has returned high.
- R7: A start bit is accepted only if the line is still low at the mid-bit sample, 8 ticks after the falling edge. Otherwise the receiver returns to idle and nothing is queued.
- R8: If a byte completes while all 16 entries are occupied, status bit 1 is set. The new byte is discarded and the 16 stored bytes stay intact and in order.
- R9: A status-read strobe clears status bits 1 to 4. Bits 2 to 4 stay 0 until a different byte becomes the FIFO head.
- R10: Status bit 7 is 1 while at least one queued byte carries a parity, framing or break tag. A status read does not clear it.
- R11: Status bit 5 equals `tx_hold_empty`. Status bit 6 is 1 only when both `tx_hold_empty` and `tx_shift_empty` are 1.
- R12: A data-read strobe while the FIFO is empty changes nothing. `rd_data` reads 0 while the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial receive line, idle high |
| rd_data_strobe | input | 1 | Removes the FIFO head byte |
| rd_status_strobe | input | 1 | Acknowledges the sticky status bits |
| cfg_wlen | input | 2 | Data-bit count code (5 + value) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_stop2 | input | 1 | Two stop bits |
| tx_hold_empty | input | 1 | Transmit holding register empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| rd_data | output | 8 | Head byte of the receive FIFO |
| line_status | output | 8 | Line status word |

## Verification
The input synchronizer adds two clocks. The deframer queues a byte one clock after the mid-bit sample of the first stop bit, and the FIFO count changes on the following edge. Because of this, a received byte is checked only after one further full idle bit time. A break is checked only after the line has been held low for well over the character time.

Status bits 5 and 6 pass straight through from their inputs and are sampled in the same cycle. The effects of a strobe are sampled at the falling edge after the rising edge that registers the strobe. All stimulus is driven and all outputs are sampled on falling clock edges.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef struct packed {
        logic [7:0] data;
        logic       par_err;
        logic       frm_err;
        logic       brk;
    } rx_char_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_BRKCHK,
        RX_WAITHI
    } rx_state_e;

endpackage

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
    import uart_rx_pkg::*;
#(
    parameter int OSR  = 16,
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic       cfg_stop2,
    output logic       push_o,
    output rx_char_t   char_o
);
    localparam int CW   = $clog2(OSR);
    localparam int HALF = OSR / 2;
    localparam int TW   = $clog2(OSR * 13 + 1);

    typedef struct packed {
        rx_state_e       st;
        logic [CW-1:0]   cnt;
        logic [TW-1:0]   tot;
        logic [2:0]      bitn;
        logic [7:0]      shreg;
        logic            par;
        logic            par_bad;
        logic            zero;
        logic [SYNC-1:0] sync;
        logic            push;
        rx_char_t        chr;
    } state_t;

    state_t q, d;

    logic          rxd_s;
    logic [3:0]    nbits;
    logic [TW-1:0] char_ticks;
    logic [CW-1:0] last;
    logic          bit_done;
    logic [7:0]    aligned;

    assign rxd_s      = q.sync[SYNC-1];
    assign nbits      = 4'd5 + {2'b00, cfg_wlen};
    assign char_ticks = TW'(OSR) * (TW'(2) + TW'(nbits) + TW'(cfg_par_en) + TW'(cfg_stop2));
    assign last       = (q.st == RX_START) ? CW'(HALF - 1) : CW'(OSR - 1);
    assign bit_done   = os_tick && (q.cnt == last);
    assign aligned    = q.shreg >> {1'b0, 2'd3 - cfg_wlen};

    always_comb begin
        d      = q;
        d.push = 1'b0;
        d.sync = {q.sync[SYNC-2:0], rxd};
        if (os_tick && q.st != RX_IDLE && q.st != RX_WAITHI) begin
            d.cnt = q.cnt + 1'b1;
            d.tot = q.tot + 1'b1;
        end
        case (q.st)
            RX_IDLE: if (os_tick && !rxd_s) begin
                d.st  = RX_START;
                d.cnt = '0;
                d.tot = '0;
            end
            RX_START: if (bit_done) begin
                d.cnt = '0;
                if (!rxd_s) begin
                    d.st      = RX_DATA;
                    d.bitn    = '0;
                    d.par     = 1'b0;
                    d.par_bad = 1'b0;
                    d.zero    = 1'b1;
                end else begin
                    d.st = RX_IDLE;
                end
            end
            RX_DATA: if (bit_done) begin
                d.cnt   = '0;
                d.shreg = {rxd_s, q.shreg[7:1]};
                d.par   = q.par ^ rxd_s;
                d.zero  = q.zero & ~rxd_s;
                d.bitn  = q.bitn + 1'b1;
                if ({1'b0, q.bitn} + 4'd1 == nbits)
                    d.st = cfg_par_en ? RX_PAR : RX_STOP;
            end
            RX_PAR: if (bit_done) begin
                d.cnt     = '0;
                d.par_bad = q.par ^ rxd_s ^ ~cfg_par_even;
                d.zero    = q.zero & ~rxd_s;
                d.st      = RX_STOP;
            end
            RX_STOP: if (bit_done) begin
                d.cnt = '0;
                if (rxd_s) begin
                    d.push = 1'b1;
                    d.chr  = '{data: aligned, par_err: q.par_bad, frm_err: 1'b0, brk: 1'b0};
                    d.st   = RX_IDLE;
                end else if (q.zero) begin
                    d.st = RX_BRKCHK;
                end else begin
                    d.push = 1'b1;
                    d.chr  = '{data: aligned, par_err: q.par_bad, frm_err: 1'b1, brk: 1'b0};
                    d.st   = RX_WAITHI;
                end
            end
            RX_BRKCHK: if (os_tick) begin
                if (rxd_s) begin
                    d.push = 1'b1;
                    d.chr  = '{data: 8'h00, par_err: q.par_bad, frm_err: 1'b1, brk: 1'b0};
                    d.st   = RX_IDLE;
                end else if (q.tot + 1'b1 >= char_ticks) begin
                    d.push = 1'b1;
                    d.chr  = '{data: 8'h00, par_err: 1'b0, frm_err: 1'b0, brk: 1'b1};
                    d.st   = RX_WAITHI;
                end
            end
            RX_WAITHI: if (rxd_s) d.st = RX_IDLE;
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= RX_IDLE;
            q.sync <= '1;
        end else begin
            q <= d;
        end
    end

    assign push_o = q.push;
    assign char_o = q.chr;

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push_i,
    input  rx_char_t char_i,
    input  logic     pop_i,
    output rx_char_t head_o,
    output logic     empty_o,
    output logic     full_o,
    output logic     err_any_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        rx_char_t [DEPTH-1:0] mem;
        logic [AW-1:0]        wr;
        logic [AW-1:0]        rd;
        logic [CW-1:0]        cnt;
        logic [CW-1:0]        errs;
    } state_t;

    state_t q, d;
    logic do_push, do_pop, in_err, out_err;

    assign empty_o   = (q.cnt == '0);
    assign full_o    = (q.cnt == CW'(DEPTH));
    assign head_o    = q.mem[q.rd];
    assign err_any_o = (q.errs != '0);
    assign do_push   = push_i && !full_o;
    assign do_pop    = pop_i && !empty_o;
    assign in_err    = char_i.par_err | char_i.frm_err | char_i.brk;
    assign out_err   = head_o.par_err | head_o.frm_err | head_o.brk;

    always_comb begin
        d = q;
        if (do_push) begin
            d.mem[q.wr] = char_i;
            d.wr        = (q.wr == AW'(DEPTH - 1)) ? '0 : q.wr + 1'b1;
        end
        if (do_pop)
            d.rd = (q.rd == AW'(DEPTH - 1)) ? '0 : q.rd + 1'b1;
        d.cnt  = q.cnt + CW'(do_push) - CW'(do_pop);
        d.errs = q.errs + CW'(do_push && in_err) - CW'(do_pop && out_err);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
    import uart_rx_pkg::*;
#(
    parameter int OSR        = 16,
    parameter int FIFO_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic       rd_data_strobe,
    input  logic       rd_status_strobe,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic       cfg_stop2,
    input  logic       tx_hold_empty,
    input  logic       tx_shift_empty,
    output logic [7:0] rd_data,
    output logic [7:0] line_status
);
    typedef struct packed {
        logic ovr;
        logic head_ack;
    } state_t;

    state_t   q, d;
    logic     rx_push, fifo_empty, fifo_full, err_any, pop_eff;
    rx_char_t rx_char, head;

    uart_rx_deframer #(.OSR(OSR), .SYNC(2)) u_deframer (
        .clk          (clk),
        .rst_n        (rst_n),
        .os_tick      (os_tick),
        .rxd          (rxd),
        .cfg_wlen     (cfg_wlen),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_even (cfg_par_even),
        .cfg_stop2    (cfg_stop2),
        .push_o       (rx_push),
        .char_o       (rx_char)
    );

    uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (rx_push),
        .char_i    (rx_char),
        .pop_i     (rd_data_strobe),
        .head_o    (head),
        .empty_o   (fifo_empty),
        .full_o    (fifo_full),
        .err_any_o (err_any)
    );

    assign pop_eff = rd_data_strobe && !fifo_empty;

    always_comb begin
        d     = q;
        d.ovr = (q.ovr && !rd_status_strobe) || (rx_push && fifo_full);
        if (pop_eff || (rx_push && fifo_empty)) d.head_ack = 1'b0;
        else if (rd_status_strobe)              d.head_ack = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic show_head;
    assign show_head = !fifo_empty && !q.head_ack;

    assign rd_data     = fifo_empty ? 8'h00 : head.data;
    assign line_status = {err_any,
                          tx_hold_empty & tx_shift_empty,
                          tx_hold_empty,
                          show_head & head.brk,
                          show_head & head.frm_err,
                          show_head & head.par_err,
                          q.ovr,
                          !fifo_empty};

endmodule

// File: rtl/uart_rx_lsr_chk.sv
module uart_rx_lsr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_status_strobe,
    input logic       rd_data_strobe,
    input logic       tx_shift_empty,
    input logic [7:0] line_status,
    input logic       push,
    input logic       full
);
    assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push && full |=> line_status[1]);

    assert_overrun_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status_strobe && !(push && full) |=> !line_status[1]);

    assert_head_err_in_fifo_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|line_status[4:2]) |-> line_status[7]);

    assert_err_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        line_status[7] |-> line_status[0]);

    assert_tx_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        line_status[6] |-> (line_status[5] && tx_shift_empty));

    assert_empty_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_strobe && !line_status[0] && !push |=> !line_status[0]);
endmodule

bind uart_rx_lsr uart_rx_lsr_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .rd_status_strobe (rd_status_strobe),
    .rd_data_strobe   (rd_data_strobe),
    .tx_shift_empty   (tx_shift_empty),
    .line_status      (line_status),
    .push             (rx_push),
    .full             (fifo_full)
);

// File: tb/sim_uart_rx_lsr.sv
module sim_uart_rx_lsr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rd_data_strobe = 1'b0;
    logic       rd_status_strobe = 1'b0;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       tx_hold_empty = 1'b0;
    logic       tx_shift_empty = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] line_status;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    localparam int BIT_CLKS = 32;

    always #4 clk = ~clk;
    always @(negedge clk) os_tick <= ~os_tick;

    uart_rx_lsr u0 (.*);

    typedef struct packed {
        logic [1:0] wlen;
        logic       pen;
        logic       peven;
        logic       stop2;
        logic [7:0] data;
        logic       flip;
        logic       stopv;
        logic [7:0] xdata;
        logic [7:0] xls;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd3, 1'b0, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b1, 8'h5A, 8'h61},
        '{2'd0, 1'b0, 1'b0, 1'b0, 8'hF3, 1'b0, 1'b1, 8'h13, 8'h61},
        '{2'd2, 1'b1, 1'b1, 1'b0, 8'h45, 1'b0, 1'b1, 8'h45, 8'h61},
        '{2'd3, 1'b1, 1'b0, 1'b0, 8'h81, 1'b1, 1'b1, 8'h81, 8'hE5},
        '{2'd3, 1'b1, 1'b1, 1'b1, 8'hC3, 1'b0, 1'b1, 8'hC3, 8'h61},
        '{2'd1, 1'b0, 1'b0, 1'b0, 8'h2A, 1'b0, 1'b0, 8'h2A, 8'hE9},
        '{2'd3, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 8'h61}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_bits(input int n);
        repeat (n * BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_bit(input logic v);
        rxd = v;
        wait_bits(1);
    endtask

    task automatic send_frame(input logic [7:0] data, input logic flip, input logic stopv);
        int  n;
        logic p;
        n = 5 + int'(cfg_wlen);
        p = 1'b0;
        send_bit(1'b0);
        for (int i = 0; i < n; i++) begin
            send_bit(data[i]);
            p = p ^ data[i];
        end
        if (cfg_par_en) send_bit((cfg_par_even ? p : ~p) ^ flip);
        send_bit(stopv);
        if (cfg_stop2) send_bit(1'b1);
        send_bit(1'b1);
    endtask

    task automatic set_cfg(input logic [1:0] w, input logic pe, input logic ev, input logic s2);
        cfg_wlen = w; cfg_par_en = pe; cfg_par_even = ev; cfg_stop2 = s2;
    endtask

    task automatic pulse_status();
        rd_status_strobe = 1'b1;
        @(negedge clk);
        rd_status_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_read();
        rd_data_strobe = 1'b1;
        @(negedge clk);
        rd_data_strobe = 1'b0;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 status in reset", line_status, 8'h00);
        rst_n = 1'b1;
        tx_hold_empty = 1'b1;
        tx_shift_empty = 1'b1;
        wait_bits(1);
        check("R1 status after reset", line_status, 8'h60);
        check("R1 R12 rd_data empty", rd_data, 8'h00);

        // Table walk: R2 R3 R4 R5 R9
        for (int v = 0; v < NV; v++) begin
            set_cfg(VECS[v].wlen, VECS[v].pen, VECS[v].peven, VECS[v].stop2);
            send_frame(VECS[v].data, VECS[v].flip, VECS[v].stopv);
            check($sformatf("R2 R4 R5 status vec%0d", v), line_status, VECS[v].xls);
            pulse_status();
            check($sformatf("R9 ack vec%0d", v), line_status & 8'h1F, 8'h01);
            check($sformatf("R3 data vec%0d", v), rd_data, VECS[v].xdata);
            pulse_read();
            check($sformatf("R2 drained vec%0d", v), line_status, 8'h60);
        end

        set_cfg(2'd3, 1'b0, 1'b0, 1'b0);

        // R12: read on empty
        pulse_read();
        check("R12 empty read status", line_status, 8'h60);
        check("R12 empty read data", rd_data, 8'h00);

        // R7: short glitch is not a start bit
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        wait_bits(12);
        check("R7 glitch ignored", line_status, 8'h60);
        send_frame(8'hA7, 1'b0, 1'b1);
        check("R7 next frame data", rd_data, 8'hA7);
        pulse_read();

        // R6: break
        rxd = 1'b0;
        wait_bits(9);
        check("R6 no byte before char time", line_status, 8'h60);
        wait_bits(6);
        check("R6 still one byte while low", line_status, 8'hF1);
        rxd = 1'b1;
        wait_bits(2);
        check("R6 break status", line_status, 8'hF1);
        check("R6 break data", rd_data, 8'h00);
        pulse_read();
        check("R6 single break byte", line_status, 8'h60);

        // R9 R10: error tag of head vs any
        set_cfg(2'd3, 1'b1, 1'b1, 1'b0);
        send_frame(8'h11, 1'b1, 1'b1);
        send_frame(8'h22, 1'b0, 1'b1);
        check("R4 R10 bad head", line_status, 8'hE5);
        pulse_status();
        check("R9 R10 bit7 kept after status read", line_status, 8'hE1);
        check("R2 head data", rd_data, 8'h11);
        pulse_read();
        check("R10 good head clears bit7", line_status, 8'h61);
        check("R2 second data", rd_data, 8'h22);
        pulse_read();
        send_frame(8'h33, 1'b0, 1'b1);
        send_frame(8'h44, 1'b1, 1'b1);
        check("R10 bad byte behind good head", line_status, 8'hE1);
        pulse_read();
        check("R4 bad byte reaches head", line_status, 8'hE5);
        check("R2 bad byte data", rd_data, 8'h44);
        pulse_read();
        check("R2 empty again", line_status, 8'h60);

        // R8: overrun
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 17; k++) send_frame(8'(k * 3 + 1), 1'b0, 1'b1);
        check("R8 overrun status", line_status, 8'h63);
        pulse_status();
        check("R9 overrun cleared", line_status, 8'h61);
        for (int k = 0; k < 16; k++) begin
            check($sformatf("R8 kept byte %0d", k), rd_data, 8'(k * 3 + 1));
            pulse_read();
        end
        check("R8 new byte discarded", line_status, 8'h60);

        // R11: transmitter flags
        tx_hold_empty = 1'b1; tx_shift_empty = 1'b0;
        @(negedge clk);
        check("R11 holding empty only", line_status, 8'h20);
        tx_hold_empty = 1'b0; tx_shift_empty = 1'b1;
        @(negedge clk);
        check("R11 shift empty only", line_status, 8'h00);
        tx_hold_empty = 1'b1; tx_shift_empty = 1'b1;
        @(negedge clk);
        check("R11 both empty", line_status, 8'h60);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule